// File: doc/BRIEF.md
# Single-Channel Prescaled PWM Timer

This block produces one pulse-width-modulated output from a 16-bit up-counter. A power-of-two prescaler slows the kernel clock down to a counting tick. The counter runs from zero up to a programmable reload limit and then wraps to zero. While the count is above a programmable threshold, the output holds its active level. A configuration bit can invert the output.

Software drives the block through a small word-addressed register port with a single-cycle write strobe and a combinational read. The enable state decides which registers will accept a write. Prescaler and polarity accept writes only while the timer is disabled. Reload limit and threshold accept writes only while it is enabled.

Writes to the reload limit and to the threshold are not applied at once. Each is committed a fixed number of kernel-clock cycles after the write. At that moment a sticky status flag is raised, and it stays set until software writes a one to the matching bit of the clear register. A running counter picks up committed values at its next wrap.

Top module: `lp_pwm_timer`

## Requirements
- R1: Register map, by address. 0 is control: bit0 = enable, bit1 = run. 1 is configuration: bits 2:0 = prescale exponent, bit3 = invert. 2 is reload limit. 3 is threshold. 4 is status, read-only: bit0 = threshold-done, bit1 = reload-done. 5 is flag clear, write-only, and reads as 0.
- R2: After reset, the reload limit reads 0xFFFF. Threshold, control, configuration and status all read 0, and `pwm_out` is low.
- R3: A write to the configuration register while enable is set is ignored, and the register keeps its previous value.
- R4: A write to the reload limit or the threshold while enable is clear is ignored. The old value stays, and no done flag is raised.
- R5: An accepted reload or threshold write is committed on the 3rd rising edge after the edge that took the write. Until then, readback shows the old value and the done flag does not rise. On the commit edge, the new value appears and the done flag is set.
- R6: Writing a 1 to bit n of the clear register clears the matching done flag. If a commit and a clear reach the same flag on the same edge, the flag ends up set.
- R7: When running, one period lasts (reload+1)·2^exponent kernel cycles. The output is active while the count is strictly greater than the threshold, so the active time is reload − threshold ticks. A threshold at or above the reload limit gives no active time.
- R8: The invert bit flips the output level, in every state.
- R9: A control write sets enable from bit0. Run is set only if bit1 is written as 1 and enable was already set before that write, so starting takes two writes. A write that clears enable also clears run. While the timer is not running, the counter holds 0 and the output sits at its inactive level.
- R10: While the counter is running, a newly committed reload or threshold value takes effect at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
On one edge, a delayed commit of a threshold write and a software clear of the same done flag can both happen. The bench provokes this by counting edges from the threshold write and placing the clear-register write so that it lands exactly on the third edge after the write. The flag is then read, and it must still be set, because the commit wins. A second clear, with nothing pending, must then bring the flag to zero.

// File: rtl/lpt_pkg.sv
// Package: shared register addresses and field positions of the PWM timer.
// Assumes word addressing with a 3-bit address.
package lpt_pkg;
    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_CFG    = 3'd1,
        A_RELOAD = 3'd2,
        A_THRESH = 3'd3,
        A_STAT   = 3'd4,
        A_CLR    = 3'd5
    } lpt_addr_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RUN_BIT = 1;
    localparam int FLAG_THR_BIT = 0;
    localparam int FLAG_RLD_BIT = 1;
endpackage

// File: rtl/lpt_prescaler.sv
// Module: power-of-two tick generator.
// Emits one tick every 2^exp cycles while run is high; the divider holds 0 when not running.
module lpt_prescaler #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] exp_i,
    output logic          tick
);
    localparam int DW = (1 << PW) - 1;

    logic [DW-1:0] div_q;
    logic [DW-1:0] mask;

    // Mask of the divider bits that must all be one for a tick.
    always_comb mask = ~({DW{1'b1}} << exp_i);

    // Free-running divider, cleared while the timer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/lpt_wr_delay.sv
// Module: delayed-commit holding register.
// A write is held for LAT cycles and then copied into the visible value; commit pulses on that edge.
// A new write while one is pending restarts the delay with the new data.
module lpt_wr_delay #(
    parameter int           W    = 16,
    parameter int           LAT  = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value_q,
    output logic         commit
);
    localparam int DW = $clog2(LAT + 1);

    logic [DW-1:0] wait_q;
    logic [W-1:0]  pend_q;

    assign commit = (wait_q == DW'(1));

    // Delay counter and pending data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            pend_q <= '0;
        end else if (wr) begin
            wait_q <= DW'(LAT);
            pend_q <= wdata;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // Visible value, updated on the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      value_q <= INIT;
        else if (commit) value_q <= pend_q;
    end
endmodule

// File: rtl/lpt_counter.sv
// Module: wrapping up-counter with threshold comparison and polarity.
// Working copies of limit and threshold load at each wrap, and continuously while idle.
module lpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         inv,
    input  logic [W-1:0] limit_c,
    input  logic [W-1:0] thresh_c,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] limit_o,
    output logic         pwm_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_a;
    logic [W-1:0] thr_a;

    // Count, wrap and reload the working copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_a <= '0;
            thr_a <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            lim_a <= limit_c;
            thr_a <= thresh_c;
        end else if (tick) begin
            if (cnt_q == lim_a) begin
                cnt_q <= '0;
                lim_a <= limit_c;
                thr_a <= thresh_c;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign limit_o = lim_a;
    assign pwm_o   = (run && (cnt_q > thr_a)) ^ inv;
endmodule

// File: rtl/lp_pwm_timer.sv
// Module: single-channel PWM timer with register port (top).
// Assumes one write per strobe cycle and reads that are sampled combinationally.
// Configuration is writable only while disabled; limit and threshold only while enabled.
module lp_pwm_timer
    import lpt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PW  = 3,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          pwm_out
);
    logic          en_q, run_q, inv_q, rld_ok_q, thr_ok_q;
    logic [PW-1:0] exp_q;
    logic [CW-1:0] limit_v, thresh_v, cnt_w, lim_act_w;
    logic          rld_commit, thr_commit, tick;
    logic          wr_ctrl, wr_cfg, wr_rld, wr_thr, wr_clr;

    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_cfg  = reg_we && (reg_addr == A_CFG) && !en_q;
    assign wr_rld  = reg_we && (reg_addr == A_RELOAD) && en_q;
    assign wr_thr  = reg_we && (reg_addr == A_THRESH) && en_q;
    assign wr_clr  = reg_we && (reg_addr == A_CLR);

    // Control: enable from bit0; run needs a prior enable; disabling clears run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= reg_wdata[CTRL_EN_BIT];
            run_q <= reg_wdata[CTRL_EN_BIT] && reg_wdata[CTRL_RUN_BIT] && en_q;
        end
    end

    // Configuration: prescale exponent and invert bit, locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            inv_q <= 1'b0;
        end else if (wr_cfg) begin
            exp_q <= reg_wdata[PW-1:0];
            inv_q <= reg_wdata[PW];
        end
    end

    // Sticky done flags: commit sets, clear-register write clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_ok_q <= 1'b0;
            thr_ok_q <= 1'b0;
        end else begin
            if (rld_commit)                               rld_ok_q <= 1'b1;
            else if (wr_clr && reg_wdata[FLAG_RLD_BIT])   rld_ok_q <= 1'b0;
            if (thr_commit)                               thr_ok_q <= 1'b1;
            else if (wr_clr && reg_wdata[FLAG_THR_BIT])   thr_ok_q <= 1'b0;
        end
    end

    lpt_wr_delay #(.W(CW), .LAT(LAT), .INIT({CW{1'b1}})) u_rld (
        .clk(clk), .rst_n(rst_n), .wr(wr_rld), .wdata(reg_wdata),
        .value_q(limit_v), .commit(rld_commit)
    );

    lpt_wr_delay #(.W(CW), .LAT(LAT), .INIT('0)) u_thr (
        .clk(clk), .rst_n(rst_n), .wr(wr_thr), .wdata(reg_wdata),
        .value_q(thresh_v), .commit(thr_commit)
    );

    lpt_prescaler #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .exp_i(exp_q), .tick(tick)
    );

    lpt_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .inv(inv_q),
        .limit_c(limit_v), .thresh_c(thresh_v),
        .cnt_o(cnt_w), .limit_o(lim_act_w), .pwm_o(pwm_out)
    );

    // Read mux for the register port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_EN_BIT]  = en_q;
                reg_rdata[CTRL_RUN_BIT] = run_q;
            end
            A_CFG:    reg_rdata[PW:0] = {inv_q, exp_q};
            A_RELOAD: reg_rdata = limit_v;
            A_THRESH: reg_rdata = thresh_v;
            A_STAT: begin
                reg_rdata[FLAG_RLD_BIT] = rld_ok_q;
                reg_rdata[FLAG_THR_BIT] = thr_ok_q;
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_checker.sv
// Module: assertion checker bound into the PWM timer top.
// Assumes it observes the top's ports and a few of its internal state signals.
module lpt_checker
    import lpt_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [CW-1:0] reg_wdata,
    input logic          pwm_out,
    input logic          en_q,
    input logic          run_q,
    input logic          inv_q,
    input logic [PW-1:0] exp_q,
    input logic          rld_ok_q,
    input logic          thr_ok_q,
    input logic          thr_commit,
    input logic [CW-1:0] cnt_w,
    input logic [CW-1:0] lim_act_w
);
    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CFG && en_q) |=> ($stable(exp_q) && $stable(inv_q)));

    a_r5_no_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rld_ok_q) |-> !$past(reg_we && reg_addr == A_RELOAD));

    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLR && reg_wdata[FLAG_THR_BIT]) |=>
            (!thr_ok_q || $past(thr_commit)));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w <= lim_act_w);

    a_r9_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> en_q);

    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (pwm_out == inv_q));
endmodule

bind lp_pwm_timer lpt_checker #(.CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pwm_out(pwm_out), .en_q(en_q), .run_q(run_q),
    .inv_q(inv_q), .exp_q(exp_q), .rld_ok_q(rld_ok_q), .thr_ok_q(thr_ok_q),
    .thr_commit(thr_commit), .cnt_w(cnt_w), .lim_act_w(lim_act_w)
);

// File: tb/sim_lp_pwm_timer.sv
// Bench: directed scenarios for the PWM timer, one task per scenario.
module sim_lp_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lp_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write: present at a falling edge, taken at the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic t_reset;
        int v;
        rd(3'd2, v); check("R2 reload reset", v, 16'hFFFF);
        rd(3'd3, v); check("R2 threshold reset", v, 0);
        rd(3'd0, v); check("R2 control reset", v, 0);
        rd(3'd1, v); check("R2 config reset", v, 0);
        rd(3'd4, v); check("R2 status reset", v, 0);
        check("R2 output reset", int'(pwm_out), 0);
    endtask

    // R5: commit three edges after the write edge.
    task automatic t_latency;
        int v;
        wr(3'd0, 16'h1);
        wr(3'd2, 16'd4);
        @(negedge clk);
        @(negedge clk);
        rd(3'd4, v); check("R5 flag not yet set", v & 2, 0);
        rd(3'd2, v); check("R5 old value before commit", v, 16'hFFFF);
        @(negedge clk);
        rd(3'd4, v); check("R5 flag set on commit", v & 2, 2);
        rd(3'd2, v); check("R5 new value on commit", v, 4);
        wr(3'd3, 16'd1);
        repeat (4) @(negedge clk);
        rd(3'd4, v); check("R5 threshold flag", v, 3);
        wr(3'd5, 16'h3);
        rd(3'd4, v); check("R6 clear both flags", v, 0);
    endtask

    task automatic t_basic;
        int h, v;
        wr(3'd0, 16'h3);
        rd(3'd0, v); check("R9 run after enable", v, 3);
        repeat (20) @(negedge clk);
        count_high(50, h); check("R7 duty limit4 thr1", h, 30);
    endtask

    task automatic t_cfg_locked;
        int v;
        wr(3'd1, 16'h5);
        rd(3'd1, v); check("R3 config ignored while enabled", v, 0);
    endtask

    task automatic t_prescale;
        int h, v;
        wr(3'd0, 16'h0);
        rd(3'd0, v); check("R9 disable clears run", v, 0);
        check("R9 idle output", int'(pwm_out), 0);
        wr(3'd1, 16'h2);
        rd(3'd1, v); check("R1 config written while disabled", v, 2);
        wr(3'd0, 16'h3);
        rd(3'd0, v); check("R9 run needs prior enable", v, 1);
        count_high(50, h); check("R9 no output when not running", h, 0);
        wr(3'd0, 16'h3);
        repeat (40) @(negedge clk);
        count_high(100, h); check("R7 prescale 4 duty", h, 60);
    endtask

    task automatic t_invert;
        int h;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h8);
        check("R8 inverted idle level", int'(pwm_out), 1);
        wr(3'd0, 16'h1);
        wr(3'd0, 16'h3);
        repeat (20) @(negedge clk);
        count_high(50, h); check("R8 inverted duty", h, 20);
    endtask

    task automatic t_locked_disabled;
        int v;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h0);
        wr(3'd5, 16'h3);
        wr(3'd2, 16'd7);
        wr(3'd3, 16'd2);
        repeat (5) @(negedge clk);
        rd(3'd2, v); check("R4 reload ignored while disabled", v, 4);
        rd(3'd3, v); check("R4 threshold ignored while disabled", v, 1);
        rd(3'd4, v); check("R4 no flag while disabled", v, 0);
    endtask

    task automatic t_wrap_update;
        int h;
        wr(3'd0, 16'h1);
        wr(3'd0, 16'h3);
        repeat (20) @(negedge clk);
        wr(3'd2, 16'd9);
        repeat (30) @(negedge clk);
        count_high(100, h); check("R10 new limit after wrap", h, 80);
    endtask

    // R6: clear write lands on the commit edge of a threshold write.
    task automatic t_collision;
        int v;
        wr(3'd5, 16'h3);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 16'd9;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(3'd4, v); check("R6 set wins over clear", v & 1, 1);
        wr(3'd5, 16'h1);
        rd(3'd4, v); check("R6 later clear", v & 1, 0);
    endtask

    task automatic t_thr_at_limit;
        int h;
        repeat (30) @(negedge clk);
        count_high(100, h); check("R7 threshold equal to limit", h, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_basic;
        t_cfg_locked;
        t_prescale;
        t_invert;
        t_locked_disabled;
        t_wrap_update;
        t_collision;
        t_thr_at_limit;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule